// File: doc/BRIEF.md
# Ring Occupancy Counter with Doorbell

This block tracks how many entries sit in one hardware queue. The same block serves both a transmit ring and the completion ring that pairs with it. A producer raises a one-cycle push strobe for each entry it adds. The consumer writes a doorbell with a signed count of entries it has taken off the ring. The block applies both to a registered occupancy count.

From that count the block drives a level `pending` output, which is high while the queue holds anything. A scheduler or interrupt collector can watch this line directly. The block also emits two one-cycle events. `up_evt` fires when the queue goes from empty to holding something. `down_evt` fires when it returns to empty. Arithmetic that would leave the range 0..RING_DEPTH saturates at the limit and latches a sticky error flag. The flags clear only on reset.

All inputs are sampled on a rising clock edge. The occupancy, `pending`, both events and both flags take their new values on that same edge.

Top module: `ring_occupancy_tracker`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises with no strobes applied, `occupancy` is 0 and `pending`, `up_evt`, `down_evt`, `underflow` and `overflow` are all 0.
- R2: A cycle with `push` high and `db_wr` low raises `occupancy` by exactly one after the clock edge, unless the result would exceed RING_DEPTH.
- R3: A cycle with `db_wr` high applies `db_cnt` as a two's-complement signed value. A positive value lowers `occupancy` by that amount, and a negative value raises it by the magnitude.
- R4: `pending` is 1 exactly when `occupancy` is non-zero.
- R5: `up_evt` is high for exactly the one cycle after an edge that moves `occupancy` from 0 to a non-zero value.
- R6: `down_evt` is high for exactly the one cycle after an edge that moves `occupancy` from a non-zero value to 0.
- R7: When `push` and `db_wr` arrive in the same cycle, the net of +1 and the signed count is applied in one step. An event is produced only if emptiness differs before and after that step.
- R8: If the net result would go below 0, `occupancy` becomes 0 and `underflow` is set. `underflow` then stays 1 until reset.
- R9: If the net result would exceed RING_DEPTH, `occupancy` becomes RING_DEPTH and `overflow` is set. `overflow` then stays 1 until reset.
- R10: `up_evt` and `down_evt` are never high in the same cycle.
- R11: A cycle with no strobe, or with a doorbell count of 0 and no push, leaves `occupancy` unchanged and produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | One entry added by the producer this cycle |
| db_wr | input | 1 | Doorbell write strobe |
| db_cnt | input | DB_W | Signed doorbell count; positive values remove entries |
| occupancy | output | $clog2(RING_DEPTH+1) | Current number of entries in the queue |
| pending | output | 1 | Level: queue is non-empty |
| up_evt | output | 1 | One-cycle pulse on the change from empty to non-empty |
| down_evt | output | 1 | One-cycle pulse on the change from non-empty to empty |
| underflow | output | 1 | Sticky: a step tried to go below zero |
| overflow | output | 1 | Sticky: a step tried to exceed RING_DEPTH |

## Verification
The bound checker watches a set of cycle-local invariants on every cycle:
- the pending level matches a non-zero count;
- an event agrees with the emptiness before and after the edge;
- the two events never coincide;
- the count never exceeds RING_DEPTH;
- the error flags never fall;
- an isolated push steps by one;
- an idle cycle holds the count.

Other behaviours can only be shown by scenarios that the bench drives and compares against its own model:
- the exact signed arithmetic of a doorbell;
- the net result when a push and a doorbell collide;
- the saturation values at both limits;
- the reset state.

// File: rtl/ring_occupancy_tracker.sv
module ring_occupancy_tracker #(
  parameter int RING_DEPTH = 64,
  parameter int DB_W       = 8,
  localparam int CNT_W     = $clog2(RING_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             db_wr,
  input  logic [DB_W-1:0]  db_cnt,
  output logic [CNT_W-1:0] occupancy,
  output logic             pending,
  output logic             up_evt,
  output logic             down_evt,
  output logic             underflow,
  output logic             overflow
);
  localparam int NW = CNT_W + DB_W + 2;
  localparam logic signed [NW-1:0] LIMIT = NW'(RING_DEPTH);

  logic signed [NW-1:0] occ_s, inc_s, dec_s, sum;
  logic [CNT_W-1:0] nxt;
  logic below, above;

  assign occ_s = signed'({{(NW-CNT_W){1'b0}}, occupancy});
  assign inc_s = push ? NW'(1) : '0;
  assign dec_s = db_wr ? signed'({{(NW-DB_W){db_cnt[DB_W-1]}}, db_cnt}) : '0;
  assign sum   = occ_s + inc_s - dec_s;
  assign below = sum < 0;
  assign above = sum > LIMIT;
  assign nxt   = below ? '0 : above ? CNT_W'(RING_DEPTH) : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occupancy <= '0;
      pending   <= 1'b0;
      up_evt    <= 1'b0;
      down_evt  <= 1'b0;
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      occupancy <= nxt;
      pending   <= nxt != '0;
      up_evt    <= (occupancy == '0) && (nxt != '0);
      down_evt  <= (occupancy != '0) && (nxt == '0);
      underflow <= underflow | below;
      overflow  <= overflow | above;
    end
  end
endmodule

// File: rtl/ring_occupancy_tracker_chk.sv
module ring_occupancy_tracker_chk #(
  parameter int RING_DEPTH = 64,
  parameter int CNT_W      = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push,
  input logic             db_wr,
  input logic [CNT_W-1:0] occupancy,
  input logic             pending,
  input logic             up_evt,
  input logic             down_evt,
  input logic             underflow,
  input logic             overflow
);
  a_r4_pending_level: assert property (@(posedge clk) disable iff (!rst_n)
    pending == (occupancy != '0));
  a_r5_up_edge: assert property (@(posedge clk) disable iff (!rst_n)
    up_evt |-> (occupancy != '0 && $past(occupancy) == '0));
  a_r6_down_edge: assert property (@(posedge clk) disable iff (!rst_n)
    down_evt |-> (occupancy == '0 && $past(occupancy) != '0));
  a_r10_no_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_evt && down_evt));
  a_r9_cap: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(RING_DEPTH));
  a_r8_sticky_uf: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(underflow));
  a_r9_sticky_of: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(overflow));
  a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !db_wr) |=> (occupancy == $past(occupancy) + 1'b1 || occupancy == CNT_W'(RING_DEPTH)));
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !db_wr) |=> ($stable(occupancy) && !up_evt && !down_evt));
endmodule

bind ring_occupancy_tracker ring_occupancy_tracker_chk #(
  .RING_DEPTH(RING_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .db_wr(db_wr),
  .occupancy(occupancy), .pending(pending), .up_evt(up_evt),
  .down_evt(down_evt), .underflow(underflow), .overflow(overflow)
);

// File: tb/ring_occupancy_tracker_test.sv
`timescale 1ns/1ps
module ring_occupancy_tracker_test;
  localparam int DEPTH = 64;
  localparam int DBW   = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0, push = 1'b0, db_wr = 1'b0;
  logic [DBW-1:0] db_cnt = '0;
  logic [CW-1:0] occupancy;
  logic pending, up_evt, down_evt, underflow, overflow;

  int errors = 0, checks = 0;
  int m_occ = 0;
  bit m_uf = 0, m_of = 0, m_up = 0, m_dn = 0;

  always #4 clk = ~clk;

  ring_occupancy_tracker #(.RING_DEPTH(DEPTH), .DB_W(DBW)) uut (
    .clk(clk), .rst_n(rst_n), .push(push), .db_wr(db_wr), .db_cnt(db_cnt),
    .occupancy(occupancy), .pending(pending), .up_evt(up_evt),
    .down_evt(down_evt), .underflow(underflow), .overflow(overflow));

  function automatic int signed_cnt(logic [DBW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(string req);
    chk(req, int'(occupancy), m_occ);
    chk("R4 pending", int'(pending), int'(m_occ != 0));
    chk("R5 up_evt", int'(up_evt), int'(m_up));
    chk("R6 down_evt", int'(down_evt), int'(m_dn));
    chk("R8 underflow", int'(underflow), int'(m_uf));
    chk("R9 overflow", int'(overflow), int'(m_of));
    chk("R10 exclusive", int'(up_evt && down_evt), 0);
  endtask

  task automatic cyc(bit p, bit w, int c, string req);
    int n;
    push = p; db_wr = w; db_cnt = DBW'(c);
    n = m_occ + (p ? 1 : 0) - (w ? signed_cnt(DBW'(c)) : 0);
    m_up = (m_occ == 0) && (n > 0);
    m_dn = (m_occ != 0) && (n <= 0);
    if (n < 0) begin n = 0; m_uf = 1; end
    if (n > DEPTH) begin n = DEPTH; m_of = 1; end
    m_occ = n;
    @(negedge clk);
    compare(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; push = 0; db_wr = 0; db_cnt = '0;
    repeat (3) @(negedge clk);
    m_occ = 0; m_uf = 0; m_of = 0; m_up = 0; m_dn = 0;
    compare("R1 reset occupancy");
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    @(negedge clk);
    do_reset();
    cyc(0, 0, 0, "R1 idle after reset");
    cyc(1, 0, 0, "R2 first push / R5 up");
    cyc(1, 0, 0, "R2 push");
    cyc(1, 0, 0, "R2 push");
    cyc(0, 1, 2, "R3 doorbell positive");
    cyc(0, 1, -3, "R3 doorbell negative adds");
    cyc(0, 1, 0, "R11 zero doorbell");
    cyc(0, 0, 0, "R11 idle");
    cyc(0, 1, 4, "R6 drain to empty");
    cyc(1, 1, 1, "R7 collide from empty no event");
    cyc(1, 0, 0, "R2 push to one");
    cyc(1, 1, 1, "R7 collide net zero");
    cyc(1, 1, 2, "R7 collide to empty");
    cyc(1, 1, -2, "R7 collide up");
    cyc(0, 1, 9, "R8 underflow saturates");
    cyc(0, 0, 0, "R8 flag sticky");
    for (int i = 0; i < DEPTH + 5; i++) cyc(1, 0, 0, "R9 fill and saturate");
    cyc(0, 1, -10, "R9 negative doorbell past cap");
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      bit p = ($urandom_range(0, 9) < 6);
      bit w = ($urandom_range(0, 9) < 3);
      int c = int'($urandom_range(0, 9)) - 2;
      cyc(p, w, c, "R7 random net update");
    end
    do_reset();
    cyc(0, 0, 0, "R1 idle after second reset");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule